// File: doc/BRIEF.md
# Slot-Selected Clock Divider with Power-Down Gating

This block sits between a frequency synthesizer core and its output pad. It holds four configuration slots, each with a feedback multiplier code, a reference divider code, spread-spectrum settings, a pad drive bit and an output divide ratio. A two-bit select input picks the active slot. The multiplier, divider, spread and drive fields of that slot go to the synthesizer core. The divide ratio turns the VCO clock into the output clock, with a 50% duty cycle for odd ratios as well as even ones.

A power-down input stops the core and releases the output pad at once. When it is released, the output stays off until a settle interval has run out. The interval is counted in reference-clock cycles, and a longer one applies when the active slot has spread enabled. The slots form a register array loaded through a simple write port. A change of select takes effect only at the end of an output period, while the output is low, so the output never carries a truncated pulse.

Top module: `synth_cfg_divider`

## Requirements
- R1: A write with `cfg_we_i` high stores `cfg_wdata_i` into slot `cfg_addr_i` at the rising edge of `clk_vco_i`. The word holds m code in bits [10:0], n code in [20:11], divide ratio in [25:21], spread enable in [26], spread down-mode in [27], spread depth in [31:28] and drive-high in [32]. While the output is disabled, the m, n, spread and drive fields of slot `sel_i` appear on the outputs one `clk_vco_i` edge after `sel_i` changes.
- R2: While `rst_ni` is low, the active slot is slot 3, and `core_en_o` and `clk_oe_o` are low. Slot k resets to m code k with all other fields zero, so `m_code_o` reads 3 and every other field output reads 0.
- R3: The m and n codes (multiplier minus one, range 0..2047; divider minus one, range 0..1023) pass to the outputs unchanged at both ends of their ranges.
- R4: With the output enabled, each high pulse and each low pulse of `clk_o` lasts R half-periods of `clk_vco_i`, where R is the active divide ratio. The period is therefore R cycles, with 50% duty for both odd and even R.
- R5: A stored divide ratio below 2 acts as 2, and one above 20 acts as 20.
- R6: Driving `pd_ni` low forces `clk_oe_o` and `clk_o` low at once. `core_en_o` falls within two rising edges of `clk_ref_i`.
- R7: After `pd_ni` rises, `core_en_o` is high after two rising edges of `clk_ref_i`. `clk_oe_o` stays low for at least L+2 reference cycles and is high within L+8 of them. L is `SETTLE_SPRD_CYC` when the active slot has spread enabled and `SETTLE_PLAIN_CYC` otherwise (clocks of equal frequency).
- R8: A change of `sel_i` or of the active slot's ratio takes effect at the next end of an output period. Every pulse of `clk_o` has the whole length of either the old or the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco_i | input | 1 | VCO clock to be divided |
| clk_ref_i | input | 1 | Reference clock for settle timing |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_addr_i | input | 2 | Slot written |
| cfg_wdata_i | input | 33 | Slot contents |
| sel_i | input | 2 | Slot select |
| pd_ni | input | 1 | Power-down, active low |
| core_en_o | output | 1 | Synthesizer core enable |
| m_code_o | output | 11 | Feedback multiplier minus one |
| n_code_o | output | 10 | Reference divider minus one |
| sprd_en_o | output | 1 | Spread modulation on |
| sprd_down_o | output | 1 | 1 = down spread, 0 = centre spread |
| sprd_depth_o | output | 4 | Spread depth code |
| drive_hi_o | output | 1 | High pad drive selected |
| clk_o | output | 1 | Divided clock |
| clk_oe_o | output | 1 | Pad enable; low means high impedance |

## Verification
A divider counter that escapes its ratio, or a ratio register that misses the clamp, shows as a pulse of the wrong length in `clk_o` within one output period. The sweep over all 32 ratio codes measures every high and low pulse in half-cycles, so such a fault cannot go unseen. A slot index loaded in the middle of a period shows as a pulse whose length is neither the old nor the new ratio, in the very period of the switch. A settle counter that runs early or late, or that ignores the spread bit, shows as `clk_oe_o` rising outside its window a few tens of cycles after the power-down release.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int M_W    = 11;
  localparam int N_W    = 10;
  localparam int OD_W   = 5;
  localparam int SD_W   = 4;
  localparam int OD_MIN = 2;
  localparam int OD_MAX = 20;

  // packed MSB first: drive at top, m code at bit 0
  typedef struct packed {
    logic            drive_hi;
    logic [SD_W-1:0] sprd_depth;
    logic            sprd_down;
    logic            sprd_en;
    logic [OD_W-1:0] odiv;
    logic [N_W-1:0]  n_code;
    logic [M_W-1:0]  m_code;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  function automatic logic [OD_W-1:0] clamp_ratio(input logic [OD_W-1:0] r);
    if (r < OD_W'(OD_MIN)) return OD_W'(OD_MIN);
    if (r > OD_W'(OD_MAX)) return OD_W'(OD_MAX);
    return r;
  endfunction
endpackage

// File: rtl/slot_bank.sv
module slot_bank import sdiv_pkg::*; #(
  parameter int SLOTS = 4,
  localparam int SEL_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] waddr_i,
  input  slot_t            wdata_i,
  input  logic [SEL_W-1:0] ra_i,
  input  logic [SEL_W-1:0] rb_i,
  output slot_t            rda_o,
  output slot_t            rdb_o
);
  slot_t mem_q [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[k] <= '{m_code: M_W'(k), default: '0};
      end else if (we_i && waddr_i == SEL_W'(k)) begin
        mem_q[k] <= wdata_i;
      end
    end
  end

  assign rda_o = mem_q[ra_i];
  assign rdb_o = mem_q[rb_i];
endmodule

// File: rtl/ratio_div.sv
module ratio_div import sdiv_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [OD_W-1:0] nxt_ratio_i,
  output logic            load_o,
  output logic            clk_o
);
  logic [OD_W-1:0] ratio_q, cnt_q, cnt_inc;
  logic            out_p_q, out_n_q, wrap;

  assign cnt_inc = cnt_q + OD_W'(1);
  assign wrap    = (cnt_q == ratio_q - OD_W'(1));
  assign load_o  = !run_i || wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= OD_W'(OD_MIN);
      cnt_q   <= OD_W'(OD_MIN - 1);
      out_p_q <= 1'b0;
    end else if (!run_i) begin
      // park one step before wrap so the first enabled edge starts a full high phase
      ratio_q <= nxt_ratio_i;
      cnt_q   <= nxt_ratio_i - OD_W'(1);
      out_p_q <= 1'b0;
    end else if (wrap) begin
      ratio_q <= nxt_ratio_i;
      cnt_q   <= '0;
      out_p_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_inc;
      out_p_q <= (cnt_inc < (ratio_q >> 1));
    end
  end

  // half-cycle stretch for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_n_q <= 1'b0;
    else         out_n_q <= out_p_q;
  end

  assign clk_o = ratio_q[0] ? (out_p_q | out_n_q) : out_p_q;

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q < ratio_q);
  p_ratio_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= OD_W'(OD_MIN) && ratio_q <= OD_W'(OD_MAX));
  p_switch_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wrap) |-> !clk_o);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_PLAIN_CYC = 100000,
  parameter int SETTLE_SPRD_CYC  = 350000,
  localparam int LIM_MAX = (SETTLE_PLAIN_CYC > SETTLE_SPRD_CYC) ? SETTLE_PLAIN_CYC : SETTLE_SPRD_CYC,
  localparam int CNT_W   = $clog2(LIM_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic sprd_en_i,
  output logic core_en_o,
  output logic ready_o
);
  logic [1:0]       pd_s_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc, lim;
  logic             ready_q;

  assign core_en_o = pd_s_q[1];
  assign ready_o   = ready_q;
  assign cnt_inc   = cnt_q + CNT_W'(1);
  assign lim       = sprd_en_i ? CNT_W'(SETTLE_SPRD_CYC) : CNT_W'(SETTLE_PLAIN_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_s_q  <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      pd_s_q <= {pd_s_q[0], pd_ni};
      if (!core_en_o) begin
        cnt_q   <= '0;
        ready_q <= 1'b0;
      end else if (!ready_q) begin
        cnt_q   <= cnt_inc;
        ready_q <= (cnt_inc >= lim);
      end
    end
  end

  p_settle_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> cnt_q >= CNT_W'(SETTLE_PLAIN_CYC));
  p_down_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_en_o |=> !ready_q);
endmodule

// File: rtl/synth_cfg_divider.sv
module synth_cfg_divider import sdiv_pkg::*; #(
  parameter int SLOTS            = 4,
  parameter int SETTLE_PLAIN_CYC = 100000,
  parameter int SETTLE_SPRD_CYC  = 350000,
  localparam int SEL_W = $clog2(SLOTS)
) (
  input  logic              clk_vco_i,
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_addr_i,
  input  logic [SLOT_W-1:0] cfg_wdata_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pd_ni,
  output logic              core_en_o,
  output logic [M_W-1:0]    m_code_o,
  output logic [N_W-1:0]    n_code_o,
  output logic              sprd_en_o,
  output logic              sprd_down_o,
  output logic [SD_W-1:0]   sprd_depth_o,
  output logic              drive_hi_o,
  output logic              clk_o,
  output logic              clk_oe_o
);
  slot_t            act_cfg, sel_cfg;
  logic [SEL_W-1:0] act_idx_q;
  logic [1:0]       run_s_q;
  logic             run, ready, load, div_clk;

  slot_bank #(.SLOTS(SLOTS)) u_bank (
    .clk_i   (clk_vco_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .waddr_i (cfg_addr_i),
    .wdata_i (slot_t'(cfg_wdata_i)),
    .ra_i    (act_idx_q),
    .rb_i    (sel_i),
    .rda_o   (act_cfg),
    .rdb_o   (sel_cfg)
  );

  settle_timer #(
    .SETTLE_PLAIN_CYC (SETTLE_PLAIN_CYC),
    .SETTLE_SPRD_CYC  (SETTLE_SPRD_CYC)
  ) u_settle (
    .clk_i     (clk_ref_i),
    .rst_ni    (rst_ni),
    .pd_ni     (pd_ni),
    .sprd_en_i (act_cfg.sprd_en),
    .core_en_o (core_en_o),
    .ready_o   (ready)
  );

  // ready crosses into the VCO domain
  always_ff @(posedge clk_vco_i or negedge rst_ni) begin
    if (!rst_ni) run_s_q <= '0;
    else         run_s_q <= {run_s_q[0], ready};
  end
  assign run = run_s_q[1];

  ratio_div u_div (
    .clk_i       (clk_vco_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .nxt_ratio_i (clamp_ratio(sel_cfg.odiv)),
    .load_o      (load),
    .clk_o       (div_clk)
  );

  // slot index moves together with the divide ratio
  always_ff @(posedge clk_vco_i or negedge rst_ni) begin
    if (!rst_ni)   act_idx_q <= SEL_W'(SLOTS - 1);
    else if (load) act_idx_q <= sel_i;
  end

  assign m_code_o     = act_cfg.m_code;
  assign n_code_o     = act_cfg.n_code;
  assign sprd_en_o    = act_cfg.sprd_en;
  assign sprd_down_o  = act_cfg.sprd_down;
  assign sprd_depth_o = act_cfg.sprd_depth;
  assign drive_hi_o   = act_cfg.drive_hi;
  assign clk_oe_o     = run & pd_ni;
  assign clk_o        = div_clk & clk_oe_o;

  p_sel_follow_r1: assert property (@(posedge clk_vco_i) disable iff (!rst_ni)
    !run |=> act_idx_q == $past(sel_i));
endmodule

// File: tb/synth_cfg_divider_test.sv
module synth_cfg_divider_test;
  localparam int PLAIN = 40;
  localparam int SPRD  = 120;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [32:0] wdata = '0;
  logic [1:0]  sel = '0;
  logic        pd_ni = 1'b0;
  logic        core_en, sprd_en, sprd_down, drive_hi, clk_out, clk_oe;
  logic [10:0] m_code;
  logic [9:0]  n_code;
  logic [3:0]  depth;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int sh_m [4], sh_n [4], sh_od [4], sh_se [4], sh_sd [4], sh_dp [4], sh_dr [4];

  always #10 clk = ~clk;

  synth_cfg_divider #(.SETTLE_PLAIN_CYC(PLAIN), .SETTLE_SPRD_CYC(SPRD)) uut (
    .clk_vco_i(clk), .clk_ref_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .sel_i(sel), .pd_ni(pd_ni), .core_en_o(core_en),
    .m_code_o(m_code), .n_code_o(n_code), .sprd_en_o(sprd_en),
    .sprd_down_o(sprd_down), .sprd_depth_o(depth), .drive_hi_o(drive_hi),
    .clk_o(clk_out), .clk_oe_o(clk_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clamp_exp(input int r);
    if (r < 2) return 2;
    if (r > 20) return 20;
    return r;
  endfunction

  // pulse tracker in half-cycle units, sampled a quarter period after each edge
  int   run_len = 0;
  int   pulse_cnt = 0;
  int   last_len = 0;
  logic prev_lvl = 1'b0;
  always @(posedge clk or negedge clk) begin
    #5;
    if (!clk_oe) begin
      run_len  = 0;
      prev_lvl = 1'b0;
    end else if (clk_out == prev_lvl) begin
      run_len++;
    end else begin
      if (run_len > 0) begin
        last_len = run_len;
        pulse_cnt++;
      end
      prev_lvl = clk_out;
      run_len  = 1;
    end
  end

  task automatic get_pulse(output int len);
    int c;
    c = pulse_cnt;
    wait (pulse_cnt != c);
    len = last_len;
  endtask

  task automatic write_slot(input int a, input int m, input int n, input int od,
                            input int se, input int sd, input int dp, input int dr);
    @(negedge clk);
    we    = 1'b1;
    addr  = 2'(a);
    wdata = {1'(dr), 4'(dp), 1'(sd), 1'(se), 5'(od), 10'(n), 11'(m)};
    @(negedge clk);
    we = 1'b0;
    sh_m[a] = m; sh_n[a] = n; sh_od[a] = od; sh_se[a] = se;
    sh_sd[a] = sd; sh_dp[a] = dp; sh_dr[a] = dr;
  endtask

  task automatic power_up(input int lim);
    int edges;
    @(negedge clk);
    pd_ni = 1'b1;
    repeat (2) @(posedge clk);
    #5 chk("R7 core_en after sync", core_en, 1);
    repeat (lim) @(posedge clk);
    #5 chk("R7 output held during settle", clk_oe, 0);
    edges = lim + 2;
    while (!clk_oe && edges < lim + 20) begin
      @(posedge clk);
      #5;
      edges++;
    end
    chk("R7 output enabled in window", int'(edges <= lim + 8 && clk_oe), 1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int len, oldr, newr;
    int pat [6] = '{2, 3, 1, 2, 3, 1};
    int ratio_of [4];

    // R2 reset state
    repeat (3) @(posedge clk);
    #5;
    chk("R2 m_code slot3", m_code, 3);
    chk("R2 n_code", n_code, 0);
    chk("R2 spread en", sprd_en, 0);
    chk("R2 drive", drive_hi, 0);
    chk("R2 core_en", core_en, 0);
    chk("R2 clk_oe", clk_oe, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    write_slot(0, 2047, 1023, 4, 0, 1, 15, 1);
    write_slot(1, 0, 0, 3, 0, 0, 1, 0);
    write_slot(2, 1234, 567, 8, 1, 0, 9, 0);
    write_slot(3, 77, 5, 20, 0, 1, 6, 1);

    // R1 / R3 routing of each slot while disabled
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      sel = 2'(k);
      @(posedge clk);
      #5;
      chk("R3 m_code", m_code, sh_m[k]);
      chk("R3 n_code", n_code, sh_n[k]);
      chk("R1 spread en", sprd_en, sh_se[k]);
      chk("R1 spread down", sprd_down, sh_sd[k]);
      chk("R1 spread depth", depth, sh_dp[k]);
      chk("R1 drive", drive_hi, sh_dr[k]);
    end

    // R7 plain settle on slot 0
    @(negedge clk);
    sel = 2'd0;
    power_up(PLAIN);

    // R4 / R5 ratio sweep over every code on the active slot
    for (int r = 0; r < 32; r++) begin
      write_slot(0, 2047, 1023, r, 0, 1, 15, 1);
      repeat (3) get_pulse(len);
      get_pulse(len);
      chk((r < 2 || r > 20) ? "R5 clamped pulse" : "R4 pulse", len, clamp_exp(r));
      get_pulse(len);
      chk((r < 2 || r > 20) ? "R5 clamped pulse" : "R4 pulse", len, clamp_exp(r));
    end

    // R8 select switching at varied phases
    ratio_of[0] = 4; ratio_of[1] = 3; ratio_of[2] = 8; ratio_of[3] = 20;
    write_slot(0, 2047, 1023, 4, 0, 1, 15, 1);
    repeat (4) get_pulse(len);
    oldr = 4;
    for (int t = 0; t < 6; t++) begin
      repeat (t * 7 + 3) @(negedge clk);
      sel  = 2'(pat[t]);
      newr = ratio_of[pat[t]];
      for (int p = 0; p < 6; p++) begin
        get_pulse(len);
        if (p >= 4) chk("R8 settled ratio", len, newr);
        else chk("R8 whole pulse", int'(len == oldr || len == newr), 1);
      end
      oldr = newr;
    end

    // R6 power-down
    @(negedge clk);
    pd_ni = 1'b0;
    #2;
    chk("R6 oe low at once", clk_oe, 0);
    chk("R6 clk low at once", clk_out, 0);
    repeat (2) @(posedge clk);
    #5 chk("R6 core_en low", core_en, 0);

    // R7 spread slot needs the longer settle
    @(negedge clk);
    sel = 2'd2;
    repeat (4) @(posedge clk);
    power_up(SPRD);
    get_pulse(len);
    get_pulse(len);
    chk("R4 pulse after spread start", len, 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule